// File: doc/BRIEF.md
# Interrupt Vector Dispatch Unit

This block collects up to sixteen level-sensitive legacy device interrupt lines and turns them into vectored interrupt deliveries to one processor. A built-in sparse table gives each legacy line a vector number. Lines with no table entry are dropped without any effect. Vector numbers are always below 0x30. When a mapped line goes high while the unit is idle, the unit marks itself busy and fills a three-word mailbox. It then raises a hard-interrupt request and pulses a wake signal, so a halted processor resumes. When a mapped line goes low while the unit is busy, the busy flag and the request drop.

The mailbox holds a single entry. A new assertion that arrives while an entry is outstanding is discarded, not queued. Line changes are found by comparing each line with the last level the unit acted on. When several lines change together, one change is handled per clock, lowest line number first. Reset is asserted asynchronously and released in step with the clock.

Top module: `ivec_dispatch`

## Requirements
- R1: After reset the status output, all three mailbox words, the request and the wake pulse are zero.
- R2: The table maps line 1 to 0x29, line 4 to 0x2B, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2A. A delivery loads mailbox word 0 with bits [5:0] = vector, bits [10:6] = 0x1F and all higher bits zero, so word 0 equals 0x7C0 | vector.
- R3: A change on a line with no table entry (any line other than 1, 4, 6, 7, 12) leaves every output unchanged.
- R4: A rising mapped line seen at a clock edge while idle sets status bit 5 and the request, and clears words 1 and 2. All of these are visible right after that edge.
- R5: A rising mapped line while busy is ignored: the status, the request and all mailbox words keep their values.
- R6: A falling mapped line while busy clears status bit 5 and the request after that edge. The mailbox words keep their values.
- R7: A falling mapped line while idle changes no output.
- R8: The wake output is high for exactly the one cycle after each delivery and low otherwise.
- R9: When several mapped lines change in the same cycle, they are handled one per clock in ascending line order.
- R10: Status bits other than bit 5 always read zero, and the delivered vector is always below 0x30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lines | input | 16 | Legacy level interrupt lines, synchronous to clk |
| ivec_status | output | 8 | Vector status; bit 5 is the busy flag |
| ivec_word0 | output | 64 | Mailbox word 0: tag 0x1F in [10:6], vector in [5:0] |
| ivec_word1 | output | 64 | Mailbox word 1, cleared on delivery |
| ivec_word2 | output | 64 | Mailbox word 2, cleared on delivery |
| hard_req | output | 1 | Hard-interrupt request to the processor |
| cpu_wake | output | 1 | One-cycle pulse on each delivery that clears the processor's halt |

## Verification
Each mapped line is raised alone from idle, which tells the table entries apart through the vector in word 0. A rise while busy and a fall while idle tell apart the two cases where the busy flag guards the mailbox. Lines 7 and 12 are raised in one cycle, and lines 1 and 4 fall in one cycle, to show the ascending service order and the one-change-per-clock handling. Unmapped lines are toggled alone to show they have no effect. Long runs of seeded random single-line and multi-line toggles are then checked against a cycle model kept in the bench.

// File: rtl/ivd_pkg.sv
package ivd_pkg;
  localparam int unsigned VEC_W    = 6;
  localparam int unsigned TAG_W    = 5;
  localparam logic [TAG_W-1:0] DATA_TAG = 5'h1F;
  localparam logic [VEC_W-1:0] VEC_LIMIT = 6'h30;

  // Sparse legacy-line remap; zero means no vector
  function automatic logic [VEC_W-1:0] remap_line(input int unsigned line);
    case (line)
      1:       return 6'h29;
      4:       return 6'h2B;
      6:       return 6'h27;
      7:       return 6'h22;
      12:      return 6'h2A;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/ivd_remap.sv
module ivd_remap #(
  parameter int unsigned N_LINES = 16
) (
  output logic [N_LINES-1:0][ivd_pkg::VEC_W-1:0] vec_tab,
  output logic [N_LINES-1:0]                     mapped
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign vec_tab[g] = ivd_pkg::remap_line(g);
    assign mapped[g]  = |vec_tab[g];
  end
endmodule

// File: rtl/ivd_edge_pick.sv
module ivd_edge_pick #(
  parameter int unsigned N_LINES = 16,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] mapped,
  output logic               ev_valid,
  output logic               ev_rise,
  output logic [IDX_W-1:0]   ev_idx
);
  logic [N_LINES-1:0] seen_q, seen_d, diff;

  always_comb begin
    diff     = (lines ^ seen_q) & mapped;
    ev_valid = 1'b0;
    ev_idx   = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (diff[i]) begin
        ev_valid = 1'b1;
        ev_idx   = IDX_W'(i);
      end
    end
    ev_rise = lines[ev_idx];
    seen_d  = seen_q;
    if (ev_valid) seen_d[ev_idx] = lines[ev_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= '0;
    else if (ev_valid) seen_q <= seen_d;
  end

  // R9: at most one line's recorded level moves per clock
  a_r9_one_per_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seen_q ^ $past(seen_q)) <= 1);
  // R3: only table lines produce events
  a_r3_unmapped_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> mapped[ev_idx]);
endmodule

// File: rtl/ivd_mailbox.sv
module ivd_mailbox #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned BUSY_BIT = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ev_valid,
  input  logic                      ev_rise,
  input  logic [ivd_pkg::VEC_W-1:0] ev_vec,
  output logic [STAT_W-1:0]         status,
  output logic [DATA_W-1:0]         word0,
  output logic [DATA_W-1:0]         word1,
  output logic [DATA_W-1:0]         word2,
  output logic                      req,
  output logic                      wake
);
  localparam int unsigned HDR_W = ivd_pkg::TAG_W + ivd_pkg::VEC_W;

  logic busy_q, req_q, wake_q, wake_d;
  logic [DATA_W-1:0] w0_q, w1_q, w2_q, w0_d;
  logic ld_en, clr_en, busy_en;

  always_comb begin
    ld_en   = ev_valid &  ev_rise & ~busy_q;
    clr_en  = ev_valid & ~ev_rise &  busy_q;
    busy_en = ld_en | clr_en;
    w0_d    = DATA_W'({ivd_pkg::DATA_TAG, ev_vec});
    wake_d  = ld_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
    end else if (busy_en) begin
      busy_q <= ld_en;
      req_q  <= ld_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      w1_q <= '0;
      w2_q <= '0;
    end else if (ld_en) begin
      w0_q <= w0_d;
      w1_q <= '0;
      w2_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  always_comb begin
    status           = '0;
    status[BUSY_BIT] = busy_q;
  end
  assign word0 = w0_q;
  assign word1 = w1_q;
  assign word2 = w2_q;
  assign req   = req_q;
  assign wake  = wake_q;

  // R5: an outstanding entry is never overwritten
  a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(w0_q));
  // R8: wake only accompanies a fresh delivery
  a_r8_wake_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> ($rose(busy_q) && req_q));
  // R10: vector range while busy
  a_r10_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (w0_q[ivd_pkg::VEC_W-1:0] < ivd_pkg::VEC_LIMIT));
  // R2: header layout of word 0
  a_r2_word0_tag: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (w0_q[HDR_W-1:ivd_pkg::VEC_W] == ivd_pkg::DATA_TAG
                && w0_q[DATA_W-1:HDR_W] == '0));
  // R6: request follows busy through clears
  a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (!req_q && !busy_q));
endmodule

// File: rtl/ivec_dispatch.sv
module ivec_dispatch #(
  parameter int unsigned N_LINES  = 16,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned BUSY_BIT = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_LINES-1:0]  irq_lines,
  output logic [STAT_W-1:0]   ivec_status,
  output logic [DATA_W-1:0]   ivec_word0,
  output logic [DATA_W-1:0]   ivec_word1,
  output logic [DATA_W-1:0]   ivec_word2,
  output logic                hard_req,
  output logic                cpu_wake
);
  localparam int unsigned IDX_W = $clog2(N_LINES);

  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [N_LINES-1:0][ivd_pkg::VEC_W-1:0] vec_tab;
  logic [N_LINES-1:0] mapped;
  logic               ev_valid, ev_rise;
  logic [IDX_W-1:0]   ev_idx;

  ivd_remap #(.N_LINES(N_LINES)) u_remap (
    .vec_tab (vec_tab),
    .mapped  (mapped)
  );

  ivd_edge_pick #(.N_LINES(N_LINES)) u_pick (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .lines    (irq_lines),
    .mapped   (mapped),
    .ev_valid (ev_valid),
    .ev_rise  (ev_rise),
    .ev_idx   (ev_idx)
  );

  ivd_mailbox #(.DATA_W(DATA_W), .STAT_W(STAT_W), .BUSY_BIT(BUSY_BIT)) u_mbox (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .ev_valid (ev_valid),
    .ev_rise  (ev_rise),
    .ev_vec   (vec_tab[ev_idx]),
    .status   (ivec_status),
    .word0    (ivec_word0),
    .word1    (ivec_word1),
    .word2    (ivec_word2),
    .req      (hard_req),
    .wake     (cpu_wake)
  );

  // R1: outputs quiet while core reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_core_n |-> (!hard_req && ivec_status == '0));
endmodule

// File: tb/tb_ivec_dispatch.sv
module tb_ivec_dispatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] irq_lines;
  logic [7:0]  ivec_status;
  logic [63:0] ivec_word0, ivec_word1, ivec_word2;
  logic        hard_req, cpu_wake;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] m_seen;
  logic        m_busy, m_wake;
  logic [63:0] m_w0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivec_dispatch dut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines),
    .ivec_status(ivec_status), .ivec_word0(ivec_word0),
    .ivec_word1(ivec_word1), .ivec_word2(ivec_word2),
    .hard_req(hard_req), .cpu_wake(cpu_wake)
  );

  function automatic logic [5:0] exp_vec(input int line);
    case (line)
      1: return 6'h29;  4: return 6'h2B;  6: return 6'h27;
      7: return 6'h22; 12: return 6'h2A;
      default: return 6'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    m_wake = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (exp_vec(i) != 0 && irq_lines[i] != m_seen[i]) begin
        if (irq_lines[i] && !m_busy) begin
          m_busy = 1'b1;
          m_w0   = 64'h7C0 | 64'(exp_vec(i));
          m_wake = 1'b1;
        end else if (!irq_lines[i] && m_busy) begin
          m_busy = 1'b0;
        end
        m_seen[i] = irq_lines[i];
        break;
      end
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " status"}, 64'(ivec_status), 64'(m_busy) << 5);
    chk({tag, " word0"}, ivec_word0, m_w0);
    chk({tag, " word1"}, ivec_word1, 64'h0);
    chk({tag, " word2"}, ivec_word2, 64'h0);
    chk({tag, " req"}, 64'(hard_req), 64'(m_busy));
    chk({tag, " wake"}, 64'(cpu_wake), 64'(m_wake));
  endtask

  // Called at a negedge; returns at the following negedge
  task automatic step(input logic [15:0] v, input string tag);
    irq_lines = v;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired (R1 R9): actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] cur;
    rst_n = 1'b0; irq_lines = '0;
    m_seen = '0; m_busy = 1'b0; m_wake = 1'b0; m_w0 = '0;
    repeat (3) @(negedge clk);
    compare_all("R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all("R1 after reset");

    // R2 / R4 / R8: each table line alone, raised then dropped
    foreach (cur[i]) begin
      if (exp_vec(i) != 0) begin
        step(16'h1 << i, "R2 R4 R8 rise");
        chk("R2 vector", ivec_word0, 64'h7C0 | 64'(exp_vec(i)));
        step(16'h1 << i, "R8 wake low");
        step(16'h0, "R6 fall");
      end
    end

    // R3: unmapped lines alone
    step(16'h0008, "R3 line3 up");
    step(16'h8000, "R3 line15 up");
    step(16'h0000, "R3 down");
    chk("R3 status", 64'(ivec_status), 64'h0);

    // R9: lines 7 and 12 together -> 7 first, 12 then ignored (R5)
    step(16'h1080, "R9 pair");
    chk("R9 lower line first", ivec_word0, 64'h7E2);
    step(16'h1080, "R5 line12 ignored");
    chk("R5 word0 held", ivec_word0, 64'h7E2);
    // R6: drop 12 clears busy, word0 retained
    step(16'h0080, "R6 fall clears");
    chk("R6 busy low", 64'(hard_req), 64'h0);
    chk("R6 word0 kept", ivec_word0, 64'h7E2);
    // R7: drop 7 while idle
    step(16'h0000, "R7 idle fall");
    chk("R7 word0 kept", ivec_word0, 64'h7E2);
    // R9: lines 1 and 4 rise together, then fall together
    step(16'h0012, "R9 rise pair");
    chk("R9 line1 first", ivec_word0, 64'h7E9);
    step(16'h0012, "R9 second");
    step(16'h0000, "R9 fall pair");
    chk("R9 fall clears", 64'(ivec_status), 64'h0);
    step(16'h0000, "R7 second fall idle");

    // Random phase: single and multi-line toggles (R4 R5 R6 R7 R10)
    void'($urandom(32'd20240611));
    cur = '0;
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(3) == 0) cur = cur ^ 16'($urandom());
      else cur[$urandom_range(15)] = ~cur[$urandom_range(15)];
      step(cur, "R4 R5 R6 R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule